// File: doc/BRIEF.md
# Stop-Release and Clock-Mode Sequencer

This block controls the system clock mode of a small 8-bit controller and does two related jobs. When the core leaves the stop state on an external interrupt, the block sends one load strobe to the wake-up timer and its prescaler. The strobe carries fixed stabilisation counts, so execution resumes only after the oscillator has settled. A control bit can suppress this load, and the timer then keeps the values software programmed before the stop.

The second job is the move from low-speed (sub-clock) operation to middle-speed operation. A register write starts it. The block turns on the main oscillator, counts a selectable number of slow-clock cycles while reporting busy, and only then changes the reported mode. Software can also select modes directly through a mode write port, except that leaving low speed is possible only through this sequenced switch.

Top module: `clk_mode_seq`

## Requirements
- R1: After reset, mode is middle speed (encoding low=00, middle=01, high=10), every control byte bit reads 0, stopped=0, tmr_load=0 and osc_en=1.
- R2: When wake is high while stopped=1 and control bit 0 is 0, the next cycle shows stopped=0 and tmr_load=1 for exactly one cycle, with tmr_load_val=0x01 and psc_load_val=0xFF.
- R3: When control bit 0 is 1 at wake, stopped returns to 0 and tmr_load stays 0.
- R4: A control write with bit 3=1 and bit 1=1, made while the mode is low speed, sets busy (read bit 4) and bit 3 in the next cycle, forces osc_en=1, and keeps the mode at low speed while busy.
- R5: A start write has no effect (bits 3 and 4 stay 0) when bit 1 of the written byte is 0, when the mode is not low speed, while stopped, or in a cycle with stop_req high.
- R6: The wait counts slow_tick pulses after the start cycle: 256 when bit 2=0 and 512 when bit 2=1. The cycle after the last counted pulse shows middle speed, with bits 3 and 4 back at 0.
- R7: osc_en is 0 exactly when the mode is low speed and busy is 0.
- R8: A mode write takes effect in the next cycle. It is ignored while busy, while stopped, for code 11, and for any code other than low while the mode is low speed.
- R9: stop_req sets stopped only while busy=0 and stopped=0; wake has no effect while stopped=0.
- R10: While busy, a control write changes only bit 0; bits 1 and 2 keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data: bit0 inhibit reload, bit1 switch enable, bit2 long wait, bit3 start |
| mode_we | input | 1 | Direct mode write strobe |
| mode_wdata | input | 2 | Requested mode code |
| stop_req | input | 1 | Core requests the stop state |
| wake | input | 1 | External interrupt wake event |
| slow_tick | input | 1 | One pulse per slow-clock cycle |
| cfg_rdata | output | 8 | Control byte readback, bit 4 is busy, bits 7..5 read 0 |
| mode | output | 2 | Current clock mode |
| osc_en | output | 1 | Main oscillator enable |
| stopped | output | 1 | Stop state active |
| tmr_load | output | 1 | One-cycle load strobe for timer and prescaler |
| tmr_load_val | output | 8 | Timer value to load |
| psc_load_val | output | 8 | Prescaler value to load |

## Verification
The assertions assume that slow_tick is a single-cycle pulse synchronous to clk and that all inputs change only between rising edges. They also assume that the 2-bit mode code 11 is never observed on the mode output. The bench drives every input on the falling edge and produces ticks from a fixed-seed random stream. It raises stop and wake with low probability, so that mode writes and start writes fall both inside and outside the busy window and inside and outside the stop state.

// File: rtl/cms_pkg.sv
package cms_pkg;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'b00,
        MODE_MID  = 2'b01,
        MODE_HIGH = 2'b10
    } mode_e;

    localparam logic [7:0] STAB_TMR_VAL = 8'h01;
    localparam logic [7:0] STAB_PSC_VAL = 8'hFF;

    typedef struct packed {
        mode_e mode;
        logic  inhibit;
        logic  sw_en;
        logic  long_wait;
    } ctl_state_t;

endpackage

// File: rtl/cms_wait_timer.sv
module cms_wait_timer #(
    parameter int WAIT_SHORT = 256,
    parameter int WAIT_LONG  = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    input  logic tick,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WAIT_LONG);
    localparam logic [CW-1:0] LIM_S = CW'(WAIT_SHORT - 1);
    localparam logic [CW-1:0] LIM_L = CW'(WAIT_LONG - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic [CW-1:0] lim;

    always_comb begin
        d    = q;
        lim  = long_sel ? LIM_L : LIM_S;
        done = q.busy && tick && (q.cnt == lim);
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = '0;
        end else if (done) begin
            d.busy = 1'b0;
            d.cnt  = '0;
        end else if (q.busy && tick) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
endmodule

// File: rtl/cms_stop_ctrl.sv
module cms_stop_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic wake,
    input  logic busy,
    input  logic inhibit,
    output logic stopped,
    output logic load
);
    typedef struct packed {
        logic stopped;
        logic load;
    } stp_t;

    stp_t q, d;

    always_comb begin
        d      = q;
        d.load = 1'b0;
        if (q.stopped) begin
            if (wake) begin
                d.stopped = 1'b0;
                d.load    = !inhibit;
            end
        end else if (stop_req && !busy) begin
            d.stopped = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stopped = q.stopped;
    assign load    = q.load;
endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
    import cms_pkg::*;
#(
    parameter int WAIT_SHORT = 256,
    parameter int WAIT_LONG  = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       mode_we,
    input  logic [1:0] mode_wdata,
    input  logic       stop_req,
    input  logic       wake,
    input  logic       slow_tick,
    output logic [7:0] cfg_rdata,
    output logic [1:0] mode,
    output logic       osc_en,
    output logic       stopped,
    output logic       tmr_load,
    output logic [7:0] tmr_load_val,
    output logic [7:0] psc_load_val
);
    ctl_state_t q, d;
    logic start, busy, done, stp;

    cms_wait_timer #(.WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG)) u_wait (
        .clk(clk), .rst_n(rst_n), .start(start), .long_sel(q.long_wait),
        .tick(slow_tick), .busy(busy), .done(done)
    );

    cms_stop_ctrl u_stop (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake(wake),
        .busy(busy), .inhibit(q.inhibit), .stopped(stp), .load(tmr_load)
    );

    always_comb begin
        d     = q;
        start = 1'b0;
        if (cfg_we) begin
            d.inhibit = cfg_wdata[0];
            if (!busy) begin
                d.sw_en     = cfg_wdata[1];
                d.long_wait = cfg_wdata[2];
                start = cfg_wdata[3] && cfg_wdata[1] && (q.mode == MODE_LOW)
                        && !stp && !stop_req;
            end
        end
        if (mode_we && !busy && !stp && (q.mode != MODE_LOW)
            && (mode_wdata != 2'b11))
            d.mode = mode_e'(mode_wdata);
        if (done)
            d.mode = MODE_MID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{mode: MODE_MID, inhibit: 1'b0, sw_en: 1'b0, long_wait: 1'b0};
        else        q <= d;
    end

    assign cfg_rdata    = {3'b000, busy, busy, q.long_wait, q.sw_en, q.inhibit};
    assign mode         = q.mode;
    assign osc_en       = (q.mode != MODE_LOW) || busy;
    assign stopped      = stp;
    assign tmr_load_val = STAB_TMR_VAL;
    assign psc_load_val = STAB_PSC_VAL;
endmodule

// File: rtl/cms_chk.sv
module cms_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic [1:0] mode,
    input logic       osc_en,
    input logic       stopped,
    input logic       tmr_load
);
    a_r2_load_at_wake: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |-> $fell(stopped));
    a_r3_load_not_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |-> !$past(cfg_rdata[0]));
    a_r4_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[4] |-> (mode == 2'b00));
    a_r6_done_to_middle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_rdata[4]) |-> (mode == 2'b01));
    a_r7_osc_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[4] |-> osc_en);
    a_r8_leave_low_by_switch: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b00 && mode != 2'b00) |-> $past(cfg_rdata[4]));
    a_r9_no_stop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(stopped && cfg_rdata[4]));
endmodule

bind clk_mode_seq cms_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .mode(mode),
    .osc_en(osc_en), .stopped(stopped), .tmr_load(tmr_load)
);

// File: tb/sim_clk_mode_seq.sv
`timescale 1ns/1ps
module sim_clk_mode_seq;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, mode_we = 0, stop_req = 0, wake = 0, slow_tick = 0;
    logic [7:0] cfg_wdata = 0;
    logic [1:0] mode_wdata = 0;
    logic [7:0] cfg_rdata, tmr_load_val, psc_load_val;
    logic [1:0] mode;
    logic osc_en, stopped, tmr_load;

    clk_mode_seq u0 (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    // reference state
    int e_mode = 1, e_cnt = 0;
    bit e_inh = 0, e_en = 0, e_lng = 0, e_busy = 0, e_stp = 0, e_load = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_cfg();
        return {e_busy, e_busy, e_lng, e_en, e_inh};
    endfunction

    task automatic compare_all();
        chk("R6/R8 mode", mode, e_mode);
        chk("R4/R5/R10 cfg_rdata", cfg_rdata, exp_cfg());
        chk("R7 osc_en", osc_en, (e_mode != 0 || e_busy) ? 1 : 0);
        chk("R9 stopped", stopped, e_stp);
        chk("R2/R3 tmr_load", tmr_load, e_load);
        if (tmr_load) begin
            chk("R2 tmr_load_val", tmr_load_val, 8'h01);
            chk("R2 psc_load_val", psc_load_val, 8'hFF);
        end
    endtask

    // one cycle: drive at falling edge, update model, check at next falling edge
    task automatic step(bit we, logic [7:0] wd, bit mwe, logic [1:0] mwd,
                        bit stp_i, bit wk, bit tk);
        bit old_busy = e_busy, old_stp = e_stp;
        int lim = e_lng ? 511 : 255;
        cfg_we = we; cfg_wdata = wd; mode_we = mwe; mode_wdata = mwd;
        stop_req = stp_i; wake = wk; slow_tick = tk;
        e_load = 0;
        if (old_stp) begin
            if (wk) begin e_stp = 0; e_load = !e_inh; end
        end else if (stp_i && !old_busy) e_stp = 1;
        if (mwe && !old_busy && !old_stp && e_mode != 0 && mwd != 2'b11) e_mode = mwd;
        if (old_busy && tk) begin
            if (e_cnt == lim) begin e_busy = 0; e_cnt = 0; e_mode = 1; end
            else e_cnt++;
        end
        if (we) begin
            e_inh = wd[0];
            if (!old_busy) begin
                e_en = wd[1]; e_lng = wd[2];
                if (wd[3] && wd[1] && e_mode == 0 && !old_stp && !stp_i) begin
                    e_busy = 1; e_cnt = 0;
                end
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n, bit tk);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tk);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode, 1);
        chk("R1 cfg_rdata", cfg_rdata, 0);
        chk("R1 stopped", stopped, 0);
        chk("R1 tmr_load", tmr_load, 0);
        chk("R1 osc_en", osc_en, 1);
        // R9: wake while running ignored; R2 stop then wake with reload
        step(0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        idle(3, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        idle(2, 0);
        // R3: inhibit set, reload suppressed
        step(1, 8'h01, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        idle(1, 0);
        // R5: start outside low speed is ignored
        step(1, 8'h0A, 0, 0, 0, 0, 0);
        // R8: go to high, code 11 ignored, then low
        step(0, 0, 1, 2'b10, 0, 0, 0);
        step(0, 0, 1, 2'b11, 0, 0, 0);
        step(0, 0, 1, 2'b00, 0, 0, 0);
        // R8: direct exit from low ignored; R7 osc off
        step(0, 0, 1, 2'b01, 0, 0, 0);
        // R5: switch-enable 0 ignored; start with stop_req same cycle ignored
        step(1, 8'h08, 0, 0, 0, 0, 0);
        step(1, 8'h0A, 0, 0, 1, 0, 0);
        step(1, 8'h0A, 0, 0, 0, 0, 0);      // R5: while stopped
        step(0, 0, 0, 0, 0, 1, 0);
        // R4/R6: short wait with tick every cycle
        step(1, 8'h0A, 0, 0, 0, 0, 0);
        step(1, 8'h07, 1, 2'b10, 1, 0, 1);   // R10 write, R8 mode write, R9 stop ignored
        idle(300, 1);
        // R6: long wait with sparse ticks
        step(0, 0, 1, 2'b00, 0, 0, 0);
        step(1, 8'h0E, 0, 0, 0, 0, 0);
        for (int i = 0; i < 1100; i++) step(0, 0, 0, 0, 0, 0, ($urandom % 2) == 0);
        // random phase
        for (int i = 0; i < 8000; i++) begin
            int r = $urandom % 100;
            step(r < 4, 8'($urandom), (r >= 4 && r < 8), 2'($urandom),
                 r == 8, r == 9 || r == 10, ($urandom % 4) != 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule